// File: doc/BRIEF.md
# Quarter-Second Real-Time Clock Counter

This block counts quarter seconds inside each minute. It runs from a 4 Hz enable that is synchronous to the processor clock. The counter steps once per tick through the values 0 to 239 and then wraps, so one full pass lasts exactly one minute. The wrap raises a sticky minute flag, and that flag drives an interrupt request. The counter keeps running whatever the processor side is doing. Only the dedicated reset input returns it to zero.

A processor reaches the block through two 8-bit registers, a control register and a data register. The data register normally mirrors the running count. Mirroring happens only while a supply-stable input is high and software has not frozen the view. To set the time, software proceeds in four steps:
- It sets the hold bit, which stops the mirroring.
- It writes the new count into the data register.
- It sets the load bit.
- It produces a rising edge on the commit bit.

The load then takes effect on the next tick, and that same tick clears the hold bit. The minute flag is acknowledged with the same commit edge. The value written in the flag position is copied into the real flag only at that edge.

Top module: `qsec_rtc`

## Requirements
- R1: Each cycle with `tick_4hz` high advances the count by one. The count never exceeds 239, and a tick at 239 returns it to 0. Without a tick the count does not change.
- R2: The tick that moves the count from 239 to 0 sets the minute flag. The flag drives `minute_irq` and reads back as bit 7 of `ctl_rd`.
- R3: `ctl_rd` carries the following fields, and bits 6 to 3 always read as 0.
  - Bit 7 is the minute flag.
  - Bit 2 is the hold bit.
  - Bit 1 is the load bit.
  - Bit 0 is the commit bit.
- R4: The minute flag changes only in two cases: a wrap, or the cycle after a 0-to-1 change of the commit bit. In the second case it takes the bit-7 value most recently written to the control register. A control write that leaves the commit bit at 1 has no effect on the flag.
- R5: At a commit edge with the load bit at 1, the data register value is captured. The next tick replaces its increment with that value. At a commit edge with the load bit at 0, the count is not touched.
- R6: A captured load value above 239 is applied as 239. The tick after that wraps to 0 and sets the minute flag.
- R7: While the hold bit (bit 2) is 1, `dat_rd` is not refreshed from the count. The next tick clears the hold bit.
- R8: While `supply_ok` is 1 and the hold bit is 0, `dat_rd` equals the count one cycle after the count changes. A software write to the data register in that state is overwritten on the following cycle.
- R9: While `supply_ok` is 0, `dat_rd` keeps its value, and counting and minute-flag setting continue.
- R10: If a wrap and a commit-edge acknowledge fall in the same cycle, the minute flag ends up set.
- R11: Reset sets the count, the data register, all control bits and `minute_irq` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_4hz | input | 1 | One-cycle 4 Hz enable, synchronous to clk |
| supply_ok | input | 1 | Supply stable; allows data register refresh |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write value |
| dat_wr_en | input | 1 | Data register write strobe |
| dat_wr_data | input | 8 | Data register write value |
| ctl_rd | output | 8 | Control register read value |
| dat_rd | output | 8 | Data register read value |
| minute_irq | output | 1 | Minute interrupt request |

## Verification
Counting is tried in two ways.
- Long tick bursts from reset land on 1, 5, 55 and 239. These separate a correct 240-state wrap from an off-by-one wrap, and an early or late minute flag.
- Loads of an in-range value and of an out-of-range value (250) show whether the clamp works and whether a load replaces an increment or adds to it.

Acknowledge and commit traffic is tried in three ways.
- A commit with the load bit at 0 shows whether LOAD is sampled at the commit edge.
- A repeated commit with no new edge must leave the flag alone.
- A commit edge aligned with the wrap tick shows the priority of the hardware set.

Refresh is tried with `supply_ok` low across a whole minute, and with a software write made while the hold bit is clear.

// File: rtl/qrtc_pkg.sv
package qrtc_pkg;

  localparam int unsigned HOLD_POS = 2;
  localparam int unsigned LOAD_POS = 1;
  localparam int unsigned SET_POS  = 0;

  typedef struct packed {
    logic min_req;
    logic hold;
    logic load;
    logic commit;
  } ctl_fields_t;

endpackage

// File: rtl/qrtc_ctl.sv
module qrtc_ctl
  import qrtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  ctl_fields_t wr_fields,
  input  logic        tick,
  input  logic        wrap_hit,
  output logic        min_flag,
  output logic        hold_bit,
  output logic        load_bit,
  output logic        commit_bit,
  output logic        commit_edge
);

  logic min_req_q, min_req_d;
  logic hold_q, hold_d;
  logic load_q, load_d;
  logic commit_q, commit_d;
  logic commit_prev_q;
  logic flag_q, flag_d;

  assign commit_edge = commit_q & ~commit_prev_q;

  always_comb begin
    min_req_d = min_req_q;
    load_d    = load_q;
    commit_d  = commit_q;
    hold_d    = hold_q;
    if (wr_en) begin
      min_req_d = wr_fields.min_req;
      load_d    = wr_fields.load;
      commit_d  = wr_fields.commit;
      hold_d    = wr_fields.hold;
    end else if (tick) begin
      hold_d    = 1'b0;
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (wrap_hit) begin
      flag_d = 1'b1;
    end else if (commit_edge) begin
      flag_d = min_req_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_req_q     <= 1'b0;
      hold_q        <= 1'b0;
      load_q        <= 1'b0;
      commit_q      <= 1'b0;
      commit_prev_q <= 1'b0;
      flag_q        <= 1'b0;
    end else begin
      min_req_q     <= min_req_d;
      hold_q        <= hold_d;
      load_q        <= load_d;
      commit_q      <= commit_d;
      commit_prev_q <= commit_q;
      flag_q        <= flag_d;
    end
  end

  assign min_flag   = flag_q;
  assign hold_bit   = hold_q;
  assign load_bit   = load_q;
  assign commit_bit = commit_q;

endmodule

// File: rtl/qrtc_count.sv
module qrtc_count #(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned LAST_Q = 239
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             commit_edge,
  input  logic             load_bit,
  input  logic [REG_W-1:0] load_src,
  output logic [REG_W-1:0] cnt,
  output logic             wrap_hit,
  output logic             load_pend
);

  localparam logic [REG_W-1:0] LAST_V = REG_W'(LAST_Q);
  localparam logic [REG_W-1:0] ONE_V  = REG_W'(1);

  logic [REG_W-1:0] cnt_q, cnt_d;
  logic [REG_W-1:0] ld_val_q, ld_val_d;
  logic             pend_q, pend_d;
  logic [REG_W-1:0] ld_clamped;

  assign ld_clamped = (ld_val_q > LAST_V) ? LAST_V : ld_val_q;
  assign wrap_hit   = tick & ~pend_q & (cnt_q == LAST_V);

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (pend_q) begin
        cnt_d = ld_clamped;
      end else if (cnt_q == LAST_V) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + ONE_V;
      end
    end
  end

  always_comb begin
    pend_d   = pend_q;
    ld_val_d = ld_val_q;
    if (commit_edge && load_bit) begin
      pend_d   = 1'b1;
      ld_val_d = load_src;
    end else if (tick) begin
      pend_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ld_val_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      ld_val_q <= ld_val_d;
      pend_q   <= pend_d;
    end
  end

  assign cnt       = cnt_q;
  assign load_pend = pend_q;

endmodule

// File: rtl/qrtc_view.sv
module qrtc_view #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             supply_ok,
  input  logic             hold,
  input  logic [REG_W-1:0] cnt,
  output logic [REG_W-1:0] view
);

  logic [REG_W-1:0] view_q, view_d;
  logic             refresh_en;

  assign refresh_en = supply_ok & ~hold;

  always_comb begin
    view_d = view_q;
    if (wr_en) begin
      view_d = wr_data;
    end else if (refresh_en) begin
      view_d = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      view_q <= '0;
    end else begin
      view_q <= view_d;
    end
  end

  assign view = view_q;

endmodule

// File: rtl/qsec_rtc.sv
module qsec_rtc
  import qrtc_pkg::*;
#(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned LAST_Q = 239
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_4hz,
  input  logic             supply_ok,
  input  logic             ctl_wr_en,
  input  logic [REG_W-1:0] ctl_wr_data,
  input  logic             dat_wr_en,
  input  logic [REG_W-1:0] dat_wr_data,
  output logic [REG_W-1:0] ctl_rd,
  output logic [REG_W-1:0] dat_rd,
  output logic             minute_irq
);

  localparam int unsigned MIN_POS = REG_W - 1;

  ctl_fields_t      wr_fields;
  logic             unused_ctl_hi;
  logic             min_flag_w, hold_w, load_w, commit_w;
  logic             set_edge_w, wrap_w, load_pend_w;
  logic [REG_W-1:0] cnt_w;

  assign wr_fields.min_req = ctl_wr_data[MIN_POS];
  assign wr_fields.hold    = ctl_wr_data[HOLD_POS];
  assign wr_fields.load    = ctl_wr_data[LOAD_POS];
  assign wr_fields.commit  = ctl_wr_data[SET_POS];
  assign unused_ctl_hi     = ^ctl_wr_data[MIN_POS-1:HOLD_POS+1];

  qrtc_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (ctl_wr_en),
    .wr_fields   (wr_fields),
    .tick        (tick_4hz),
    .wrap_hit    (wrap_w),
    .min_flag    (min_flag_w),
    .hold_bit    (hold_w),
    .load_bit    (load_w),
    .commit_bit  (commit_w),
    .commit_edge (set_edge_w)
  );

  qrtc_count #(.REG_W(REG_W), .LAST_Q(LAST_Q)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_4hz),
    .commit_edge (set_edge_w),
    .load_bit    (load_w),
    .load_src    (dat_rd),
    .cnt         (cnt_w),
    .wrap_hit    (wrap_w),
    .load_pend   (load_pend_w)
  );

  qrtc_view #(.REG_W(REG_W)) u_view (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (dat_wr_en),
    .wr_data   (dat_wr_data),
    .supply_ok (supply_ok),
    .hold      (hold_w),
    .cnt       (cnt_w),
    .view      (dat_rd)
  );

  always_comb begin
    ctl_rd           = '0;
    ctl_rd[MIN_POS]  = min_flag_w;
    ctl_rd[HOLD_POS] = hold_w;
    ctl_rd[LOAD_POS] = load_w;
    ctl_rd[SET_POS]  = commit_w;
  end

  assign minute_irq = min_flag_w;

endmodule

// File: rtl/qsec_rtc_chk.sv
module qsec_rtc_chk
  import qrtc_pkg::*;
#(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned LAST_Q = 239
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_4hz,
  input logic             supply_ok,
  input logic             ctl_wr_en,
  input logic             dat_wr_en,
  input logic [REG_W-1:0] ctl_rd,
  input logic [REG_W-1:0] dat_rd,
  input logic             minute_irq,
  input logic [REG_W-1:0] cnt_w,
  input logic             wrap_w,
  input logic             set_edge_w,
  input logic             load_pend_w
);

  localparam logic [REG_W-1:0] LAST_V = REG_W'(LAST_Q);

  p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w <= LAST_V);

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_4hz && !load_pend_w && cnt_w == LAST_V) |=> (cnt_w == '0));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_4hz |=> $stable(cnt_w));

  p_min_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_4hz && !load_pend_w && cnt_w == LAST_V) |=> minute_irq);

  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd[REG_W-2:HOLD_POS+1] == '0);

  p_flag_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_edge_w && !wrap_w) |=> $stable(minute_irq));

  p_hold_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_4hz && !ctl_wr_en) |=> !ctl_rd[HOLD_POS]);

  p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd[HOLD_POS] && !dat_wr_en) |=> $stable(dat_rd));

  p_supply_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && !dat_wr_en) |=> $stable(dat_rd));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_w && set_edge_w) |=> minute_irq);

endmodule

bind qsec_rtc qsec_rtc_chk #(.REG_W(REG_W), .LAST_Q(LAST_Q)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_4hz    (tick_4hz),
  .supply_ok   (supply_ok),
  .ctl_wr_en   (ctl_wr_en),
  .dat_wr_en   (dat_wr_en),
  .ctl_rd      (ctl_rd),
  .dat_rd      (dat_rd),
  .minute_irq  (minute_irq),
  .cnt_w       (cnt_w),
  .wrap_w      (wrap_w),
  .set_edge_w  (set_edge_w),
  .load_pend_w (load_pend_w)
);

// File: tb/qsec_rtc_bench.sv
`timescale 1ns/1ps
module qsec_rtc_bench;

  logic       clk;
  logic       rst_n;
  logic       tick_4hz;
  logic       supply_ok;
  logic       ctl_wr_en;
  logic [7:0] ctl_wr_data;
  logic       dat_wr_en;
  logic [7:0] dat_wr_data;
  logic [7:0] ctl_rd;
  logic [7:0] dat_rd;
  logic       minute_irq;

  int n_vec;
  int n_bad;
  int cycles;

  typedef struct packed {
    logic [15:0] ticks;
    logic [7:0]  dat;
    logic        irq;
  } vec_t;

  localparam int VEC_N = 6;
  localparam vec_t VECS [VEC_N] = '{
    '{16'd1,   8'd1,   1'b0},
    '{16'd4,   8'd5,   1'b0},
    '{16'd50,  8'd55,  1'b0},
    '{16'd184, 8'd239, 1'b0},
    '{16'd1,   8'd0,   1'b1},
    '{16'd3,   8'd3,   1'b1}
  };

  qsec_rtc u_qsec_rtc (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_4hz    (tick_4hz),
    .supply_ok   (supply_ok),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_wr_data (ctl_wr_data),
    .dat_wr_en   (dat_wr_en),
    .dat_wr_data (dat_wr_data),
    .ctl_rd      (ctl_rd),
    .dat_rd      (dat_rd),
    .minute_irq  (minute_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_4hz = 1'b1;
      @(negedge clk) tick_4hz = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk);
    ctl_wr_en   = 1'b1;
    ctl_wr_data = v;
    @(negedge clk);
    ctl_wr_en   = 1'b0;
  endtask

  task automatic dat_write(input logic [7:0] v);
    @(negedge clk);
    dat_wr_en   = 1'b1;
    dat_wr_data = v;
    @(negedge clk);
    dat_wr_en   = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    rst_n = 1'b0;
    tick_4hz = 1'b0;
    supply_ok = 1'b1;
    ctl_wr_en = 1'b0;
    ctl_wr_data = '0;
    dat_wr_en = 1'b0;
    dat_wr_data = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    check("R11 reset dat", dat_rd, 0);
    check("R11 reset ctl", ctl_rd, 0);
    check("R11 reset irq", minute_irq, 0);

    // R1/R2 table walk
    for (int v = 0; v < VEC_N; v++) begin
      run_ticks(int'(VECS[v].ticks));
      check("R1 count", dat_rd, int'(VECS[v].dat));
      check("R2 irq", minute_irq, int'(VECS[v].irq));
    end

    // R3 unused bits, R4 no edge keeps flag
    ctl_write(8'h78);
    idle(1);
    check("R3 ctl layout", ctl_rd, 8'h80);
    check("R4 no edge", minute_irq, 1);

    // R4 acknowledge via edge
    ctl_write(8'h00);
    ctl_write(8'h01);
    idle(1);
    check("R4 ack irq", minute_irq, 0);
    check("R3 ctl after ack", ctl_rd, 8'h01);
    ctl_write(8'h81);
    idle(1);
    check("R4 held commit no effect", minute_irq, 0);

    // R8 software write overwritten while not held
    ctl_write(8'h00);
    dat_write(8'd50);
    idle(1);
    check("R8 overwrite", dat_rd, 3);

    // R5 load, R7 hold
    ctl_write(8'h04);
    dat_write(8'd100);
    ctl_write(8'h06);
    ctl_write(8'h07);
    idle(2);
    check("R7 held view", dat_rd, 100);
    check("R7 hold bit", ctl_rd, 8'h07);
    run_ticks(1);
    check("R5 load replaces", dat_rd, 100);
    check("R7 hold cleared", ctl_rd, 8'h03);
    run_ticks(1);
    check("R5 after load", dat_rd, 101);

    // R5 load bit low at edge
    ctl_write(8'h04);
    dat_write(8'd20);
    ctl_write(8'h05);
    idle(1);
    run_ticks(1);
    check("R5 no load", dat_rd, 102);

    // R6 clamp
    ctl_write(8'h04);
    dat_write(8'd250);
    ctl_write(8'h06);
    ctl_write(8'h07);
    idle(1);
    run_ticks(1);
    check("R6 clamp", dat_rd, 239);
    check("R6 no flag yet", minute_irq, 0);
    run_ticks(1);
    check("R6 wrap", dat_rd, 0);
    check("R6 flag", minute_irq, 1);

    // R9 supply low
    run_ticks(3);
    check("R8 mirror", dat_rd, 3);
    ctl_write(8'h00);
    ctl_write(8'h01);
    idle(1);
    check("R4 ack2", minute_irq, 0);
    supply_ok = 1'b0;
    run_ticks(237);
    check("R9 frozen", dat_rd, 3);
    check("R9 flag continues", minute_irq, 1);
    supply_ok = 1'b1;
    idle(2);
    check("R9 resume", dat_rd, 0);

    // R10 collision
    ctl_write(8'h00);
    run_ticks(239);
    check("R10 setup", dat_rd, 239);
    @(negedge clk);
    ctl_wr_en = 1'b1;
    ctl_wr_data = 8'h01;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    tick_4hz = 1'b1;
    @(negedge clk);
    tick_4hz = 1'b0;
    idle(1);
    check("R10 set wins", minute_irq, 1);
    check("R10 wrapped", dat_rd, 0);
    ctl_write(8'h00);
    ctl_write(8'h01);
    idle(1);
    check("R10 later ack", minute_irq, 0);

    // R11 mid-run reset
    run_ticks(7);
    ctl_write(8'h86);
    rst_n = 1'b0;
    idle(2);
    check("R11 dat", dat_rd, 0);
    check("R11 ctl", ctl_rd, 0);
    rst_n = 1'b1;
    idle(1);
    run_ticks(1);
    check("R11 count restart", dat_rd, 1);

    finish_run();
  end

endmodule